// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block steps the column address of an SDRAM read or write burst. A column command arrives with a start column, a burst length code and an ordering select. The block captures these and then puts out one column address per clock. A flag marks the final beat. Within a programmed window of 1, 2, 4 or 8 beats, the address moves in either sequential or interleaved order. In full-page mode it walks across all 512 columns and keeps going until something ends it.

A burst-stop request ends a burst of any length. A new column command may arrive on any clock, including in the middle of a burst, and starts a fresh sequence from its own start column. Command sequencing, the data path and refresh sit outside this block.

Top module: `colgen_burst_addr`

## Requirements
- R1: While rst_n is low at a rising edge, the following cycle shows col_valid = 0, last_beat = 0 and col_addr = 0. When col_valid is 0, col_addr is always 0.
- R2: A rising edge with cmd_start = 1 gives col_valid = 1 and col_addr = cmd_col in the next cycle. This holds on any clock, including in the middle of a burst, which then restarts at beat 0.
- R3: bl_code selects the burst length: 0, 1, 2 and 3 give 1, 2, 4 and 8 beats, and 7 selects full page. The reserved codes 4, 5 and 6 behave as length 1.
- R4: In sequential order, beat i of a windowed burst of length BL uses low log2(BL) bits equal to (start + i) mod BL. The upper column bits stay equal to those of the start column.
- R5: In interleaved order (ilv_mode = 1), beat i of a windowed burst uses low log2(BL) bits equal to the start's low bits XOR i. The upper bits stay fixed.
- R6: Full page increments all 9 column bits by one per beat, wrapping from 511 to 0. It ignores ilv_mode and continues until a stop or a new column command.
- R7: last_beat is 1 exactly on beat BL-1 of a windowed burst, so it is on the first beat for length 1. It is never 1 in full page. After the last beat, col_valid falls to 0 unless a new command was taken.
- R8: A rising edge with stop_req = 1 and cmd_start = 0 ends any burst, so col_valid is 0 in the next cycle. A stop while idle has no effect.
- R9: When cmd_start and stop_req are both 1 at one edge, the new command wins and its burst starts.
- R10: Mode and start column are captured only with cmd_start. Changes on cmd_col, bl_code or ilv_mode during a burst do not alter its addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_start | input | 1 | New column command; captures the start column and mode |
| cmd_col | input | 9 | Start column of the command |
| bl_code | input | 3 | Burst length code |
| ilv_mode | input | 1 | 1 = interleaved order, 0 = sequential |
| stop_req | input | 1 | Burst-stop request |
| col_addr | output | 9 | Column address of the current beat |
| col_valid | output | 1 | A burst beat is being output |
| last_beat | output | 1 | Current beat is the final one of the window |

## Verification
The bench builds the block with its defaults: a 9-bit column, a 3-bit length code, a largest window of 8 and code 7 for full page. These values bring every window size within reach, along with the reserved codes. They also make the 511-to-0 full-page wrap reachable in a few beats when the start column is near the page end. Random commands, stops and mid-burst mode changes are mixed with directed cases. The directed cases cover the window wrap at the top of a column group, interleaved order from an odd start, full page across the page boundary, and a stop arriving together with a command.

// File: rtl/colgen_pkg.sv
// Shared helpers for the burst column address generator.
// Assumes window widths never exceed 16 bits.
package colgen_pkg;

    // Low-bit mask with lg ones, used for a burst window of 2**lg beats.
    function automatic logic [15:0] low_mask(input logic [31:0] lg);
        logic [31:0] m;
        m = (32'd1 << lg) - 32'd1;
        return m[15:0];
    endfunction

endpackage

// File: rtl/colgen_mode_dec.sv
// Decodes the burst length code into a window mask and a full-page flag.
// Assumes reserved codes act as a single-beat burst. Interleave is dropped in full page.
module colgen_mode_dec #(
    parameter int COL_W     = 9,
    parameter int CODE_W    = 3,
    parameter int MAX_LOG   = 3,
    parameter int FULL_CODE = 7
) (
    input  logic [CODE_W-1:0] code,
    input  logic              ilv_in,
    output logic [COL_W-1:0]  mask,
    output logic              full,
    output logic              ilv_eff
);
    import colgen_pkg::*;

    logic [15:0] mw;

    // Map code to mask: window codes give 2**code-1, full page all ones, others zero.
    always_comb begin
        mw      = '0;
        full    = (code == CODE_W'(FULL_CODE));
        if (!full && (32'(code) <= 32'(MAX_LOG)))
            mw = low_mask(32'(code));
        mask    = full ? '1 : mw[COL_W-1:0];
        ilv_eff = ilv_in & ~full;
    end
endmodule

// File: rtl/colgen_beat_ctr.sv
// Counts beats of the running burst and flags the final one.
// Assumes mask and full are held stable by the parent for the whole burst.
module colgen_beat_ctr #(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic [COL_W-1:0] mask,
    input  logic             full,
    output logic             active,
    output logic [COL_W-1:0] idx,
    output logic             last
);
    // Final beat of a windowed burst: beat index has reached the window mask.
    assign last = active & ~full & (idx == mask);

    // Start, stop, advance or retire the burst on each clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
        end else if (start) begin
            active <= 1'b1;
            idx    <= '0;
        end else if (stop) begin
            active <= 1'b0;
        end else if (active) begin
            if (last) active <= 1'b0;
            else      idx    <= idx + 1'b1;
        end
    end

    // R2
    start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (active && idx == '0));

    // R8
    stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !start) |=> !active);

    // R7
    last_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !start) |=> !active);
endmodule

// File: rtl/colgen_addr_map.sv
// Forms the beat address from the start column and beat index.
// Bits outside the window keep the start column; bits inside follow the ordering.
module colgen_addr_map #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] idx,
    input  logic [COL_W-1:0] mask,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] seq_sum;
    logic [COL_W-1:0] ilv_xor;

    // Both candidate orderings; carries out of the window are discarded by the mask.
    always_comb begin
        seq_sum = base + idx;
        ilv_xor = base ^ idx;
    end

    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign col[b] = !mask[b] ? base[b] : (ilv ? ilv_xor[b] : seq_sum[b]);
    end
endmodule

// File: rtl/colgen_burst_addr.sv
// Top of the burst column address generator.
// Captures start column and mode on a column command, then emits one address
// per clock until the window ends, a stop arrives, or a new command restarts it.
module colgen_burst_addr #(
    parameter int COL_W     = 9,
    parameter int CODE_W    = 3,
    parameter int MAX_LOG   = 3,
    parameter int FULL_CODE = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic [CODE_W-1:0] bl_code,
    input  logic              ilv_mode,
    input  logic              stop_req,
    output logic [COL_W-1:0]  col_addr,
    output logic              col_valid,
    output logic              last_beat
);
    logic [COL_W-1:0] dec_mask;
    logic             dec_full;
    logic             dec_ilv;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] mask_q;
    logic             full_q;
    logic             ilv_q;
    logic             act;
    logic [COL_W-1:0] beat_idx;
    logic [COL_W-1:0] mapped;

    colgen_mode_dec #(
        .COL_W(COL_W), .CODE_W(CODE_W), .MAX_LOG(MAX_LOG), .FULL_CODE(FULL_CODE)
    ) i_dec (
        .code(bl_code), .ilv_in(ilv_mode),
        .mask(dec_mask), .full(dec_full), .ilv_eff(dec_ilv)
    );

    // Capture start column and decoded mode on each column command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            mask_q <= '0;
            full_q <= 1'b0;
            ilv_q  <= 1'b0;
        end else if (cmd_start) begin
            base_q <= cmd_col;
            mask_q <= dec_mask;
            full_q <= dec_full;
            ilv_q  <= dec_ilv;
        end
    end

    colgen_beat_ctr #(.COL_W(COL_W)) i_ctr (
        .clk(clk), .rst_n(rst_n), .start(cmd_start), .stop(stop_req),
        .mask(mask_q), .full(full_q),
        .active(act), .idx(beat_idx), .last(last_beat)
    );

    colgen_addr_map #(.COL_W(COL_W)) i_map (
        .base(base_q), .idx(beat_idx), .mask(mask_q), .ilv(ilv_q), .col(mapped)
    );

    // Present the address only during a burst.
    always_comb begin
        col_valid = act;
        col_addr  = act ? mapped : '0;
    end

    // R2
    first_beat_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> (col_valid && col_addr == $past(cmd_col)));

    // R4
    upper_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && !cmd_start) |=> (!col_valid ||
            ((col_addr ^ $past(col_addr)) & ~mask_q) == '0));

    // R7
    window_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_beat && !cmd_start) |=> !col_valid);

    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !col_valid |-> (col_addr == '0 && !last_beat));
endmodule

// File: tb/test_colgen_burst_addr.sv
module test_colgen_burst_addr;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_start;
    logic [8:0] cmd_col;
    logic [2:0] bl_code;
    logic       ilv_mode;
    logic       stop_req;
    logic [8:0] col_addr;
    logic       col_valid;
    logic       last_beat;

    int n_chk = 0;
    int n_err = 0;

    // bench reference state
    bit      m_act;
    int      m_base, m_len, m_idx;  // m_len 0 means full page
    bit      m_ilv;

    always #2.5 clk = ~clk;

    colgen_burst_addr i_colgen_burst_addr (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_col(cmd_col),
        .bl_code(bl_code), .ilv_mode(ilv_mode), .stop_req(stop_req),
        .col_addr(col_addr), .col_valid(col_valid), .last_beat(last_beat)
    );

    function automatic int len_of(input int code);
        if (code <= 3) return 1 << code;
        if (code == 7) return 0;
        return 1;
    endfunction

    function automatic int exp_col(input int base, input int len, input bit ilv, input int i);
        int lo;
        if (len == 0) return (base + i) % 512;
        lo = base % len;
        if (ilv) return base - lo + (lo ^ i);
        return base - lo + ((lo + i) % len);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Compare outputs with the reference state of this cycle.
    task automatic check_now();
        string tag;
        int ec, el;
        tag = (m_len == 0) ? "R6" : (m_ilv ? "R5" : "R4");
        ec  = m_act ? exp_col(m_base, m_len, m_ilv, m_idx) : 0;
        el  = (m_act && m_len != 0 && m_idx == m_len - 1) ? 1 : 0;
        chk("R8 valid", int'(col_valid), int'(m_act));
        chk(tag, int'(col_addr), ec);
        chk("R7", int'(last_beat), el);
    endtask

    // Apply inputs for the next edge and advance the reference state.
    task automatic drive(input bit st, input int col, input int code, input bit ilv, input bit sp);
        bit was_last;
        cmd_start = st; cmd_col = 9'(col); bl_code = 3'(code); ilv_mode = ilv; stop_req = sp;
        was_last = m_act && m_len != 0 && m_idx == m_len - 1;
        if (st) begin
            m_act = 1; m_idx = 0; m_base = col; m_len = len_of(code);
            m_ilv = (m_len == 0) ? 1'b0 : ilv;
        end else if (sp) begin
            m_act = 0;
        end else if (m_act) begin
            if (was_last) m_act = 0;
            else m_idx = (m_idx + 1) % 512;
        end
        @(negedge clk);
        check_now();
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) drive(0, $urandom % 512, $urandom % 8, $urandom % 2, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        n_err++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 0; cmd_start = 0; cmd_col = 0; bl_code = 0; ilv_mode = 0; stop_req = 0;
        m_act = 0; m_idx = 0; m_base = 0; m_len = 1; m_ilv = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 valid", int'(col_valid), 0);
        chk("R1 col", int'(col_addr), 0);
        chk("R1 last", int'(last_beat), 0);
        rst_n = 1;

        // R4 sequential wrap inside an 8-beat window near the page top
        drive(1, 9'h1FD, 3, 0, 0);
        idle(9);
        // R5 interleaved from odd start, 8 beats
        drive(1, 5, 3, 1, 0);
        chk("R5 first", int'(col_addr), 5);
        drive(0, 0, 0, 0, 0);
        chk("R5 second", int'(col_addr), 4);
        idle(8);
        // R6 full page across 511 -> 0, interleave ignored
        drive(1, 510, 7, 1, 0);
        drive(0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0);
        chk("R6 wrap", int'(col_addr), 0);
        idle(600);
        // R8 stop ends full page
        drive(0, 0, 0, 0, 1);
        chk("R8 stopped", int'(col_valid), 0);
        // R3 length 1 and reserved code 5
        drive(1, 77, 0, 0, 0);
        chk("R3 len1 last", int'(last_beat), 1);
        drive(1, 78, 5, 1, 0);
        chk("R3 reserved last", int'(last_beat), 1);
        idle(2);
        // R9 start with stop together
        drive(1, 200, 2, 0, 1);
        chk("R9 start wins", int'(col_valid), 1);
        // R2 restart mid-burst, R10 mode changes ignored
        drive(0, 3, 7, 1, 0);
        drive(1, 33, 2, 1, 0);
        chk("R2 restart", int'(col_addr), 33);
        idle(6);
        // R8 stop while idle
        drive(0, 0, 0, 0, 1);
        chk("R8 idle stop", int'(col_valid), 0);

        // random mix
        for (int n = 0; n < 20000; n++) begin
            int r, code;
            r = $urandom % 8;
            code = (r < 6) ? int'($urandom % 4) : int'($urandom % 8);
            drive(($urandom % 6) == 0, $urandom % 512, code, $urandom % 2, ($urandom % 40) == 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule